// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block turns edges on general-purpose input pins into interrupt requests for three I/O ports. It receives pin levels that have already been synchronized to its clock, together with each pin's current direction. It watches every input pin for a transition in the direction that software chose for that port. A qualifying transition sets a sticky per-pin status flag, and software clears a flag by writing a one to it.

Each port raises one interrupt request. A port-wide master enable gates that request, and a finer enable also applies. Port 1 enables each pin on its own. Port 0 enables its lower and upper halves as two groups. Port 2 has only the master enable, and only its low implemented pins can set flags. A wake signal is asserted whenever any port request is active, so an enabled edge can bring the system out of a sleep mode. Interrupt vectoring and priority are outside the block.

Top module: `gpio_edge_irq`

## Requirements
- R1: With `edge_fall[n]` = 0, a low-to-high change on an input pin of port n sets that pin's flag. The flag becomes visible after the first clock edge that samples the new level, and not before.
- R2: With `edge_fall[n]` = 1, a high-to-low change sets the flag, and a low-to-high change on that port sets nothing.
- R3: A pin whose `pN_dir_out` bit is 1 (output) never sets its flag, whatever its level does.
- R4: Flags are sticky. A flag stays set until a cycle in which its bit of `pN_flag_clr` is 1, and it is clear after that clock edge.
- R5: When a qualifying edge and a clear of the same bit fall in the same cycle, the flag is set after that edge.
- R6: `irq_req[n]` is 0 whenever `port_irq_en[n]` is 0, but flags are still set while it is 0. Setting the enable while a flag is pending raises the request in the same cycle.
- R7: `irq_req[1]` is 1 only if some bit i has both `p1_flags[i]` and `p1_bit_en[i]` set, and port 1 is enabled.
- R8: `p0_group_en[0]` enables `p0_flags` bits 3:0 and `p0_group_en[1]` enables bits 7:4 toward `irq_req[0]`.
- R9: Only `p2_flags` bits 4:0 can be set. Bits 7:5 stay 0, and any pending flag of port 2 raises `irq_req[2]` when port 2 is enabled.
- R10: `wake` is 1 exactly when at least one bit of `irq_req` is 1.
- R11: Reset clears all flags and requests. A pin that is already high when reset ends does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_level | input | P_W | Synchronized levels, port 0 |
| p1_level | input | P_W | Synchronized levels, port 1 |
| p2_level | input | P_W | Synchronized levels, port 2 |
| p0_dir_out | input | P_W | 1 = pin is an output, port 0 |
| p1_dir_out | input | P_W | 1 = pin is an output, port 1 |
| p2_dir_out | input | P_W | 1 = pin is an output, port 2 |
| edge_fall | input | 3 | Per port: 0 = rising edge, 1 = falling edge |
| port_irq_en | input | 3 | Per-port master interrupt enable |
| p0_group_en | input | 2 | Port 0 half enables: bit 0 for the low half, bit 1 for the high half |
| p1_bit_en | input | P_W | Port 1 per-pin enables |
| p0_flag_clr | input | P_W | Write-one-to-clear strobes, port 0 |
| p1_flag_clr | input | P_W | Write-one-to-clear strobes, port 1 |
| p2_flag_clr | input | P_W | Write-one-to-clear strobes, port 2 |
| p0_flags | output | P_W | Status flags, port 0 |
| p1_flags | output | P_W | Status flags, port 1 |
| p2_flags | output | P_W | Status flags, port 2 |
| irq_req | output | 3 | Per-port interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
A level change that is driven between two clock edges shows up in the flags after the next rising edge, because the previous-sample register is compared combinationally against the live level and the flag register takes the result at that edge. `irq_req` and `wake` are combinational from the flags and enables, so they follow an enable change within the same cycle. The bench drives every input just after a falling clock edge. It checks results at the next falling edge, which is one rising edge later. It also looks once before that rising edge, to confirm that a flag does not appear early. Enable-only changes are checked a short delay after they are driven, with no clock edge in between.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int NUM_PORTS  = 3;
    localparam int DEF_PORT_W = 8;
    localparam int DEF_P2_IMP = 5;

    localparam int PORT_GRP = 0;
    localparam int PORT_BIT = 1;
    localparam int PORT_ALL = 2;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

endpackage

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
    parameter int W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [W-1:0]           lvl,
    input  logic [W-1:0]           dir_out,
    input  gpio_irq_pkg::edge_sel_e sel,
    output logic [W-1:0]           hit
);
    import gpio_irq_pkg::*;

    logic [W-1:0] prev_q;
    logic         armed_q;
    logic [W-1:0] trans;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= lvl;
            armed_q <= 1'b1;
        end
    end

    always_comb begin
        if (sel == EDGE_FALL) trans = prev_q & ~lvl;
        else                  trans = ~prev_q & lvl;
        hit = armed_q ? (trans & ~dir_out) : '0;
    end

endmodule

// File: rtl/gpio_flag_bank.sv
module gpio_flag_bank #(
    parameter int           W    = 8,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] hit,
    input  logic [W-1:0] clr,
    output logic [W-1:0] flags
);
    logic [W-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= ((flags_q & ~clr) | hit) & IMPL;
    end

    assign flags = flags_q;

endmodule

// File: rtl/gpio_irq_gate.sv
module gpio_irq_gate #(
    parameter int W = 8
) (
    input  logic [W-1:0] flags,
    input  logic [W-1:0] en,
    input  logic         master,
    output logic         req
);
    assign req = master & (|(flags & en));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
    parameter int P_W     = gpio_irq_pkg::DEF_PORT_W,
    parameter int P2_BITS = gpio_irq_pkg::DEF_P2_IMP
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [P_W-1:0] p0_level,
    input  logic [P_W-1:0] p1_level,
    input  logic [P_W-1:0] p2_level,
    input  logic [P_W-1:0] p0_dir_out,
    input  logic [P_W-1:0] p1_dir_out,
    input  logic [P_W-1:0] p2_dir_out,
    input  logic [2:0]     edge_fall,
    input  logic [2:0]     port_irq_en,
    input  logic [1:0]     p0_group_en,
    input  logic [P_W-1:0] p1_bit_en,
    input  logic [P_W-1:0] p0_flag_clr,
    input  logic [P_W-1:0] p1_flag_clr,
    input  logic [P_W-1:0] p2_flag_clr,
    output logic [P_W-1:0] p0_flags,
    output logic [P_W-1:0] p1_flags,
    output logic [P_W-1:0] p2_flags,
    output logic [2:0]     irq_req,
    output logic           wake
);
    import gpio_irq_pkg::*;

    localparam int           HALF    = P_W / 2;
    localparam logic [P_W-1:0] ALL_MASK = {P_W{1'b1}};
    localparam logic [P_W-1:0] P2_MASK  = ALL_MASK >> (P_W - P2_BITS);

    logic [P_W-1:0] lvl_a  [NUM_PORTS];
    logic [P_W-1:0] dir_a  [NUM_PORTS];
    logic [P_W-1:0] clr_a  [NUM_PORTS];
    logic [P_W-1:0] en_a   [NUM_PORTS];
    logic [P_W-1:0] hit_a  [NUM_PORTS];
    logic [P_W-1:0] flag_a [NUM_PORTS];

    assign lvl_a[0] = p0_level;
    assign lvl_a[1] = p1_level;
    assign lvl_a[2] = p2_level;
    assign dir_a[0] = p0_dir_out;
    assign dir_a[1] = p1_dir_out;
    assign dir_a[2] = p2_dir_out;
    assign clr_a[0] = p0_flag_clr;
    assign clr_a[1] = p1_flag_clr;
    assign clr_a[2] = p2_flag_clr;

    // Fine-grained enable per port: halves, single bits, or none.
    assign en_a[PORT_GRP] = {{(P_W - HALF){p0_group_en[1]}}, {HALF{p0_group_en[0]}}};
    assign en_a[PORT_BIT] = p1_bit_en;
    assign en_a[PORT_ALL] = ALL_MASK;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        gpio_edge_det #(.W(P_W)) det_i (
            .clk     (clk),
            .rst     (rst),
            .lvl     (lvl_a[g]),
            .dir_out (dir_a[g]),
            .sel     (edge_sel_e'(edge_fall[g])),
            .hit     (hit_a[g])
        );

        if (g == PORT_ALL) begin : g_narrow
            gpio_flag_bank #(.W(P_W), .IMPL(P2_MASK)) bank_i (
                .clk (clk), .rst (rst), .hit (hit_a[g]),
                .clr (clr_a[g]), .flags (flag_a[g])
            );
        end else begin : g_full
            gpio_flag_bank #(.W(P_W), .IMPL(ALL_MASK)) bank_i (
                .clk (clk), .rst (rst), .hit (hit_a[g]),
                .clr (clr_a[g]), .flags (flag_a[g])
            );
        end

        gpio_irq_gate #(.W(P_W)) gate_i (
            .flags  (flag_a[g]),
            .en     (en_a[g]),
            .master (port_irq_en[g]),
            .req    (irq_req[g])
        );
    end

    assign p0_flags = flag_a[0];
    assign p1_flags = flag_a[1];
    assign p2_flags = flag_a[2];
    assign wake     = |irq_req;

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
    parameter int P_W     = 8,
    parameter int P2_BITS = 5
) (
    input logic           clk,
    input logic           rst,
    input logic [P_W-1:0] p1_dir_out,
    input logic [2:0]     port_irq_en,
    input logic [1:0]     p0_group_en,
    input logic [P_W-1:0] p1_bit_en,
    input logic [P_W-1:0] p0_flag_clr,
    input logic [P_W-1:0] p1_flag_clr,
    input logic [P_W-1:0] p2_flag_clr,
    input logic [P_W-1:0] p0_flags,
    input logic [P_W-1:0] p1_flags,
    input logic [P_W-1:0] p2_flags,
    input logic [2:0]     irq_req,
    input logic           wake
);
    p_out_noset_r3: assert property (@(posedge clk) disable iff (rst)
        (p1_flags & ~$past(p1_flags) & $past(p1_dir_out)) == '0);

    p_sticky_p0_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(p0_flags) & ~$past(p0_flag_clr) & ~p0_flags) == '0);
    p_sticky_p1_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(p1_flags) & ~$past(p1_flag_clr) & ~p1_flags) == '0);
    p_sticky_p2_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(p2_flags) & ~$past(p2_flag_clr) & ~p2_flags) == '0);

    p_master_r6: assert property (@(posedge clk) disable iff (rst)
        (~port_irq_en & irq_req) == 3'b000);

    p_p1_bits_r7: assert property (@(posedge clk) disable iff (rst)
        ((p1_flags & p1_bit_en) == '0) |-> !irq_req[1]);

    p_p0_grp_r8: assert property (@(posedge clk) disable iff (rst)
        (p0_group_en == 2'b00) |-> !irq_req[0]);

    p_p2_unimpl_r9: assert property (@(posedge clk) disable iff (rst)
        (p2_flags >> P2_BITS) == '0);

    p_wake_on_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_req != 3'b000) |-> wake);
    p_wake_off_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_req == 3'b000) |-> !wake);

    p_arm_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(rst, 2) && !$past(rst)) |->
        ((p0_flags == '0) && (p1_flags == '0) && (p2_flags == '0)));

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.P_W(P_W), .P2_BITS(P2_BITS)) chk_i (.*);

// File: tb/gpio_edge_irq_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_irq_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] p0_level = '0, p1_level = '0, p2_level = '0;
    logic [W-1:0] p0_dir_out = '0, p1_dir_out = '0, p2_dir_out = '0;
    logic [2:0]   edge_fall = '0, port_irq_en = '0;
    logic [1:0]   p0_group_en = '0;
    logic [W-1:0] p1_bit_en = '0;
    logic [W-1:0] p0_flag_clr = '0, p1_flag_clr = '0, p2_flag_clr = '0;
    logic [W-1:0] p0_flags, p1_flags, p2_flags;
    logic [2:0]   irq_req;
    logic         wake;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    gpio_edge_irq #(.P_W(W), .P2_BITS(5)) dut_i (.*);

    task automatic chk(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_all();
        p0_flag_clr = '1; p1_flag_clr = '1; p2_flag_clr = '1;
        tick();
        p0_flag_clr = '0; p1_flag_clr = '0; p2_flag_clr = '0;
    endtask

    task automatic t_reset();
        p0_level = 8'hFF; p1_level = 8'hFF; p2_level = 8'h1F;
        repeat (3) tick();
        chk("R11", "p0 flags in reset", p0_flags, 8'h00);
        chk("R11", "irq in reset", {5'd0, irq_req}, 8'h00);
        rst = 1'b0;
        repeat (3) tick();
        chk("R11", "p0 flags after release", p0_flags, 8'h00);
        chk("R11", "p1 flags after release", p1_flags, 8'h00);
        chk("R11", "p2 flags after release", p2_flags, 8'h00);
        p0_level = '0; p1_level = '0; p2_level = '0;
        repeat (2) tick();
        chk("R2", "falling ignored in rising mode", p1_flags, 8'h00);
    endtask

    task automatic t_rise();
        p1_level = 8'h05;
        #1;
        chk("R1", "no flag before clock edge", p1_flags, 8'h00);
        tick();
        chk("R1", "rising sets flags", p1_flags, 8'h05);
        clear_all();
        chk("R4", "clear removes flags", p1_flags, 8'h00);
    endtask

    task automatic t_fall();
        edge_fall = 3'b010;
        tick();
        p1_level = 8'h04;
        tick();
        chk("R2", "falling sets flag", p1_flags, 8'h01);
        p1_level = 8'h0C;
        tick();
        chk("R2", "rising ignored in falling mode", p1_flags, 8'h01);
        clear_all();
        edge_fall = 3'b000;
        p1_level = 8'h00;
        tick();
    endtask

    task automatic t_dir();
        p1_dir_out = 8'hF0;
        p1_level = 8'hFF;
        tick();
        chk("R3", "outputs set no flag", p1_flags, 8'h0F);
        clear_all();
        p1_level = 8'h00;
        tick();
        p1_dir_out = 8'h00;
        tick();
        chk("R3", "no late flag", p1_flags, 8'h00);
    endtask

    task automatic t_w1c();
        p0_level = 8'hAA;
        tick();
        repeat (3) tick();
        chk("R4", "flags sticky", p0_flags, 8'hAA);
        p0_flag_clr = 8'h0A;
        tick();
        p0_flag_clr = 8'h00;
        chk("R4", "partial clear", p0_flags, 8'hA0);
        clear_all();
        p0_level = 8'h00;
        tick();
    endtask

    task automatic t_collide();
        p0_level = 8'h01;
        p0_flag_clr = 8'h01;
        tick();
        p0_flag_clr = 8'h00;
        chk("R5", "edge beats clear", p0_flags, 8'h01);
        clear_all();
        p0_level = 8'h00;
        tick();
    endtask

    task automatic t_master();
        port_irq_en = 3'b000;
        p1_bit_en = 8'hFF;
        p1_level = 8'h10;
        tick();
        chk("R6", "flag set while disabled", p1_flags, 8'h10);
        chk("R6", "no request while disabled", {7'd0, irq_req[1]}, 8'h00);
        port_irq_en = 3'b010;
        #1;
        chk("R6", "request follows enable", {7'd0, irq_req[1]}, 8'h01);
        clear_all();
        chk("R6", "request drops on clear", {7'd0, irq_req[1]}, 8'h00);
        p1_level = 8'h00;
        tick();
    endtask

    task automatic t_p1bits();
        p1_bit_en = 8'h02;
        p1_level = 8'h01;
        tick();
        chk("R7", "masked bit no request", {7'd0, irq_req[1]}, 8'h00);
        p1_level = 8'h03;
        tick();
        chk("R7", "enabled bit requests", {7'd0, irq_req[1]}, 8'h01);
        clear_all();
        p1_level = 8'h00;
        tick();
    endtask

    task automatic t_p0grp();
        port_irq_en = 3'b011;
        p0_group_en = 2'b10;
        p0_level = 8'h0F;
        tick();
        chk("R8", "low half masked", {p0_flags[3:0], 3'd0, irq_req[0]}, 8'hF0);
        p0_level = 8'hFF;
        tick();
        chk("R8", "high half requests", {7'd0, irq_req[0]}, 8'h01);
        clear_all();
        p0_level = 8'h00;
        p0_group_en = 2'b01;
        tick();
        p0_level = 8'h01;
        tick();
        chk("R8", "low half requests", {7'd0, irq_req[0]}, 8'h01);
        clear_all();
        p0_level = 8'h00;
        tick();
    endtask

    task automatic t_p2();
        port_irq_en = 3'b100;
        p2_level = 8'hFF;
        tick();
        chk("R9", "only low bits flag", p2_flags, 8'h1F);
        chk("R9", "port 2 requests", {7'd0, irq_req[2]}, 8'h01);
        clear_all();
        p2_level = 8'h00;
        tick();
        p2_level = 8'hE0;
        tick();
        chk("R9", "upper bits never flag", p2_flags, 8'h00);
    endtask

    task automatic t_wake();
        chk("R10", "idle wake low", {7'd0, wake}, 8'h00);
        p2_level = 8'hE1;
        tick();
        chk("R10", "edge raises wake", {7'd0, wake}, 8'h01);
        port_irq_en = 3'b000;
        #1;
        chk("R10", "disabled port no wake", {7'd0, wake}, 8'h00);
        port_irq_en = 3'b100;
        clear_all();
        chk("R10", "wake clears", {7'd0, wake}, 8'h00);
    endtask

    initial begin
        tick();
        t_reset();
        t_rise();
        t_fall();
        t_dir();
        t_w1c();
        t_collide();
        t_master();
        t_p1bits();
        t_p0grp();
        t_p2();
        t_wake();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule